// File: doc/BRIEF.md
# Byte-Stream FPGA Configuration Loader

This block sits between a point-to-point byte link and the parallel slave configuration port of a target FPGA. It owns the link as a receiver from reset and groups the arriving bytes, least-significant byte first, into 32-bit words. While it listens, it drops every word except the start command.

The start command launches the configuration sequence. The block pulses the target's active-low program pin and waits for the target's init pin to go low and then high again. After that it forwards every later byte, unmodified, onto the data bus with a configuration-clock pulse per byte. Command words that arrive in this phase are forwarded like any other data.

Once the target raises done, the block lights its configured indicator and disables the parallel port. It then waits for the end command, counted on word boundaries from the start command. When the end command arrives it gives the link back and goes quiet until the next reset. The init and done inputs come from the target and pass through synchronizer stages before the controller uses them.

Top module: `cfgl_top`

## Requirements
- R1: After reset, prog_no, cs_no and wr_no are 1, cclk_o and configured_o are 0, and link_owned_o and byte_ready_o are 1.
- R2: A byte is taken when byte_valid_i and byte_ready_o are both high at a clock edge. Every four taken bytes form one word, and the first byte is bits 7:0. A command matches only on the fourth byte of a word, and never across word boundaries: the bytes 0xBC,0xBC,0xBC,0x00 in arrival order form 0x00BCBCBC and are not the end command.
- R3: Before the start command, each word other than 0xBCBCBCBC (the end command included) is taken in full and discarded. Program stays high and the link stays owned and ready.
- R4: On the clock edge that takes the fourth byte of 0xBCBCBCBC, prog_no goes low, byte_ready_o goes low, and cs_no stays high.
- R5: Program stays low until init_ni has been seen low through SYNC_STAGES synchronizer stages, and it rises on the following edge. Data acceptance starts only after init_ni has been seen high again in the same way, SYNC_STAGES+1 edges after the change.
- R6: In the data phase, cs_no and wr_no are 0. A byte taken at edge t appears on data_o with cclk_o high during the cycle after t, and cclk_o is low in the next cycle. byte_ready_o is low during both of these cycles.
- R7: Every byte taken in the data phase is forwarded once, in order and unmodified, including bytes that form the start or end command.
- R8: On the edge where the synchronized done is first seen in the data phase, configured_o rises, cs_no and wr_no rise, and any pulse in progress ends. A byte taken on that edge, or later, is not forwarded. configured_o then stays high until reset.
- R9: After done, the end command 0xBCBCBC00 (arrival order 0x00,0xBC,0xBC,0xBC), completed on a word boundary, drops link_owned_o and byte_ready_o on the edge that takes its last byte, and both stay low.
- R10: The word boundary is counted from the start command across the data phase and the wait after done. Bytes taken but not forwarded still count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | BYTE_W | Incoming link byte |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| prog_no | output | 1 | Target program, active low |
| init_ni | input | 1 | Target init, active low |
| cs_no | output | 1 | Target chip select, active low |
| wr_no | output | 1 | Target write enable, active low |
| cclk_o | output | 1 | Target configuration clock |
| data_o | output | BYTE_W | Target configuration data |
| done_i | input | 1 | Target done |
| configured_o | output | 1 | Target reported done |
| link_owned_o | output | 1 | Block owns the link |

## Verification
Two events can land on the same clock edge: the synchronized done arriving, and a byte being taken and strobed. When both happen together, the shutdown has to win, and the strobe for that byte has to be dropped. To provoke this, the bench streams bytes at full rate and raises done at a cycle offset that it sweeps over the whole stream, so every phase of the strobe is hit. For each taken byte, the bench uses the select level before the edge and the indicator after it to decide whether the byte should have been forwarded. It then compares the forwarded sequence and its length with that count, and checks that the end command still aligns to the byte count kept since the start command.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [1:0] {
    ST_INIT,
    ST_CONFIG,
    ST_IDLE
  } ctl_st_e;

  typedef enum logic [1:0] {
    PH_PROG,
    PH_WAIT_INIT,
    PH_DATA,
    PH_HOLD
  } cfg_ph_e;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_HIGH,
    SB_LOW
  } strobe_st_e;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int unsigned        WIDTH     = 2,
  parameter int unsigned        STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) stg_q[i] <= RESET_VAL;
        end else begin
          stg_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgl_word_asm.sv
module cfgl_word_asm #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        take_i,
  input  logic                        clear_i,
  input  logic [BYTE_W-1:0]           byte_i,
  output logic [BYTE_W*N_BYTES-1:0]   word_o,
  output logic                        last_o
);
  localparam int unsigned WORD_W = BYTE_W * N_BYTES;
  localparam int unsigned CNT_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;

  // earlier bytes move down, newest byte enters at the top
  assign word_o = {byte_i, sh_q[WORD_W-1:BYTE_W]};
  assign last_o = take_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (take_i) begin
      sh_q <= word_o;
      if (clear_i || cnt_q == CNT_LAST) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_strobe.sv
module cfgl_strobe
  import cfgl_pkg::*;
#(
  parameter int unsigned HI_CYC = 1,
  parameter int unsigned LO_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic cclk_o,
  output logic busy_o
);
  localparam int unsigned MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  strobe_st_e     st_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SB_IDLE;
      cnt_q <= '0;
    end else if (abort_i) begin
      st_q  <= SB_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SB_IDLE: if (start_i) begin
          st_q  <= SB_HIGH;
          cnt_q <= CW'(HI_CYC - 1);
        end
        SB_HIGH: if (cnt_q == '0) begin
          st_q  <= SB_LOW;
          cnt_q <= CW'(LO_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        SB_LOW: if (cnt_q == '0) st_q <= SB_IDLE;
                else             cnt_q <= cnt_q - 1'b1;
        default: st_q <= SB_IDLE;
      endcase
    end
  end

  assign cclk_o = (st_q == SB_HIGH);
  assign busy_o = (st_q != SB_IDLE);
endmodule

// File: rtl/cfgl_top.sv
module cfgl_top
  import cfgl_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned N_BYTES     = 4,
  parameter logic [BYTE_W*N_BYTES-1:0] START_KEY = 32'hBCBC_BCBC,
  parameter logic [BYTE_W*N_BYTES-1:0] END_KEY   = 32'hBCBC_BC00,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CCLK_HI     = 1,
  parameter int unsigned CCLK_LO     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              prog_no,
  input  logic              init_ni,
  output logic              cs_no,
  output logic              wr_no,
  output logic              cclk_o,
  output logic [BYTE_W-1:0] data_o,
  input  logic              done_i,
  output logic              configured_o,
  output logic              link_owned_o
);
  localparam int unsigned WORD_W = BYTE_W * N_BYTES;

  logic [1:0]        sync_q;
  logic              init_s, done_s;
  ctl_st_e           st_q, st_d;
  cfg_ph_e           ph_q, ph_d;
  logic              cfgd_q;
  logic [BYTE_W-1:0] data_q;
  logic              ready, take, in_data;
  logic              word_last, key_start, key_end;
  logic [WORD_W-1:0] word;
  logic              sb_go, sb_abort, sb_busy, sb_cclk;

  cfgl_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(2'b01)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_ni}),
    .q_o   (sync_q)
  );
  assign init_s = sync_q[0];
  assign done_s = sync_q[1];

  assign in_data = (st_q == ST_CONFIG) && (ph_q == PH_DATA);

  always_comb begin
    ready = 1'b0;
    unique case (st_q)
      ST_INIT:   ready = 1'b1;
      ST_CONFIG: begin
        unique case (ph_q)
          PH_DATA: ready = !sb_busy;
          PH_HOLD: ready = 1'b1;
          default: ready = 1'b0;
        endcase
      end
      default:   ready = 1'b0;
    endcase
  end

  assign take = byte_valid_i && ready;

  cfgl_word_asm #(
    .BYTE_W (BYTE_W),
    .N_BYTES(N_BYTES)
  ) i_word_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .clear_i(key_start || key_end),
    .byte_i (byte_i),
    .word_o (word),
    .last_o (word_last)
  );

  // commands are decoded only while listening or after done
  assign key_start = word_last && (word == START_KEY) && (st_q == ST_INIT);
  assign key_end   = word_last && (word == END_KEY) &&
                     (st_q == ST_CONFIG) && (ph_q == PH_HOLD);

  // done wins over a byte taken on the same edge
  assign sb_go    = in_data && take && !done_s;
  assign sb_abort = !in_data || done_s;

  cfgl_strobe #(
    .HI_CYC(CCLK_HI),
    .LO_CYC(CCLK_LO)
  ) i_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sb_go),
    .abort_i(sb_abort),
    .cclk_o (sb_cclk),
    .busy_o (sb_busy)
  );

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    unique case (st_q)
      ST_INIT: if (key_start) begin
        st_d = ST_CONFIG;
        ph_d = PH_PROG;
      end
      ST_CONFIG: begin
        unique case (ph_q)
          PH_PROG:      if (!init_s) ph_d = PH_WAIT_INIT;
          PH_WAIT_INIT: if (init_s)  ph_d = PH_DATA;
          PH_DATA:      if (done_s)  ph_d = PH_HOLD;
          PH_HOLD:      if (key_end) st_d = ST_IDLE;
          default:      ph_d = PH_PROG;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_INIT;
      ph_q   <= PH_PROG;
      cfgd_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (in_data && done_s) cfgd_q <= 1'b1;
      if (sb_go)             data_q <= byte_i;
    end
  end

  assign byte_ready_o = ready;
  assign prog_no      = !((st_q == ST_CONFIG) && (ph_q == PH_PROG));
  assign cs_no        = !in_data;
  assign wr_no        = !in_data;
  assign cclk_o       = sb_cclk;
  assign data_o       = data_q;
  assign configured_o = cfgd_q;
  assign link_owned_o = (st_q != ST_IDLE);
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_ready_o,
  input logic prog_no,
  input logic cs_no,
  input logic wr_no,
  input logic cclk_o,
  input logic configured_o,
  input logic link_owned_o
);
  a_r6_cclk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> !cclk_o);

  a_r6_cclk_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> (!cs_no && !wr_no && !byte_ready_o));

  a_r4_prog_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> (cs_no && !byte_ready_o && !cclk_o));

  a_r8_cfg_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> configured_o);

  a_r8_port_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |-> (cs_no && wr_no && !cclk_o));

  a_r9_release_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_owned_o |=> !link_owned_o);

  a_r9_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_owned_o |-> (!byte_ready_o && configured_o));
endmodule

bind cfgl_top cfgl_checker i_cfgl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_ready_o(byte_ready_o),
  .prog_no     (prog_no),
  .cs_no       (cs_no),
  .wr_no       (wr_no),
  .cclk_o      (cclk_o),
  .configured_o(configured_o),
  .link_owned_o(link_owned_o)
);

// File: tb/test_cfgl_top.sv
module test_cfgl_top;
  localparam int SYNC = 2;
  localparam logic [31:0] K_START = 32'hBCBC_BCBC;
  localparam logic [31:0] K_END   = 32'hBCBC_BC00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_d = '0;
  logic       valid = 1'b0;
  logic       rdy, prog_n, cs_n, wr_n, cclk, configured, owned;
  logic       init_n = 1'b1;
  logic       done = 1'b0;
  logic [7:0] dout;

  always #5 clk = ~clk;

  cfgl_top #(.SYNC_STAGES(SYNC)) i_cfgl_top (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_valid_i(valid),
    .byte_ready_o(rdy), .prog_no(prog_n), .init_ni(init_n), .cs_no(cs_n),
    .wr_no(wr_n), .cclk_o(cclk), .data_o(dout), .done_i(done),
    .configured_o(configured), .link_owned_o(owned)
  );

  int vec_n = 0, fail_n = 0;
  int sent_n, exp_fwd, acc_n, fwd_n;
  logic [7:0] sent_q [64];
  logic [7:0] fwd_q  [64];

  always @(negedge clk) begin
    if (!rst_n) fwd_n = 0;
    else if (cclk) begin
      if (fwd_n < 64) fwd_q[fwd_n] = dout;
      fwd_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      fail_n++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic pre_cs;
    @(negedge clk);
    byte_d = b;
    valid  = 1'b1;
    while (!rdy) @(negedge clk);
    pre_cs = cs_n;
    @(negedge clk);
    valid = 1'b0;
    acc_n++;
    if (!pre_cs) begin
      if (sent_n < 64) sent_q[sent_n] = b;
      sent_n++;
      if (!configured) exp_fwd++;
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = 1'b0; init_n = 1'b1; done = 1'b0;
    sent_n = 0; exp_fwd = 0; acc_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int k, input int off);
    if (k >= 4 && k < 8)  return 8'hBC;
    if (k == 8)           return 8'h00;
    if (k > 8 && k < 12)  return 8'hBC;
    return 8'((k * 53 + off * 7 + 5) & 255);
  endfunction

  task automatic run_case(input int off);
    int pad;
    do_reset();
    chk("R1 prog", prog_n, 1); chk("R1 cs", cs_n, 1); chk("R1 wr", wr_n, 1);
    chk("R1 cclk", cclk, 0); chk("R1 cfg", configured, 0);
    chk("R1 owned", owned, 1); chk("R1 ready", rdy, 1);

    if (off == 0) begin
      for (int b = 0; b < 32; b++) begin
        send_word(K_START ^ (32'h1 << b));
        chk("R3 near-start ignored", {prog_n, owned, rdy}, 3'b111);
      end
      send_word(K_END);
      chk("R3 end in listen ignored", {prog_n, owned, rdy}, 3'b111);
      send_byte(8'h11);
      for (int i = 0; i < 4; i++) send_byte(8'hBC);
      chk("R2 no sliding match", prog_n, 1);
      for (int i = 0; i < 3; i++) send_byte(8'h22);
      chk("R2 realigned filler", prog_n, 1);
    end

    send_word(K_START);
    acc_n = 0;
    chk("R4 prog low", prog_n, 0); chk("R4 ready low", rdy, 0); chk("R4 cs high", cs_n, 1);
    repeat (3) @(negedge clk);
    chk("R5 prog held", prog_n, 0);
    init_n = 1'b0;
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      chk("R5 prog before sync", prog_n, 0);
    end
    @(negedge clk);
    chk("R5 prog released", prog_n, 1); chk("R5 no data yet", rdy, 0);
    init_n = 1'b1;
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      chk("R5 wait init high", {cs_n, rdy}, 2'b10);
    end
    @(negedge clk);
    chk("R6 select", {cs_n, wr_n, rdy}, 3'b001);

    // single strobe timing
    @(negedge clk);
    byte_d = 8'hA5; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    acc_n++; sent_q[0] = 8'hA5; sent_n = 1; exp_fwd = 1;
    chk("R6 cclk high", {cclk, rdy}, 2'b10); chk("R6 data", dout, 8'hA5);
    @(negedge clk);
    chk("R6 cclk low", {cclk, rdy}, 2'b00);
    @(negedge clk);
    chk("R6 ready back", {cclk, rdy}, 2'b01);

    fork
      begin
        for (int k = 0; k < 16; k++) send_byte(pat(k, off));
      end
      begin
        repeat (off) @(negedge clk);
        done = 1'b1;
      end
    join
    repeat (SYNC + 3) @(negedge clk);
    chk("R8 configured", configured, 1);
    chk("R8 port off", {cs_n, wr_n, cclk, rdy, owned}, 5'b11011);
    chk("R8 forward count", fwd_n, exp_fwd);
    for (int i = 0; i < fwd_n && i < 64; i++) chk("R7 byte", fwd_q[i], sent_q[i]);
    if (off >= 70) chk("R7 all forwarded", fwd_n, 17);

    pad = (1 - (acc_n % 4) + 4) % 4;
    for (int i = 0; i < pad; i++) send_byte(8'h11);
    send_word(K_END);
    chk("R10 misaligned end ignored", owned, 1);
    pad = (4 - (acc_n % 4)) % 4;
    for (int i = 0; i < pad; i++) send_byte(8'h33);
    send_byte(8'hBC); send_byte(8'hBC); send_byte(8'hBC); send_byte(8'h00);
    chk("R2 byte order", owned, 1);
    send_word(K_END);
    chk("R9 released", {owned, rdy, configured}, 3'b001);
    repeat (4) @(negedge clk);
    chk("R9 stays released", {owned, rdy, cs_n}, 3'b001);
    chk("R8 no late strobe", fwd_n, exp_fwd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int off = 0; off <= 72; off += 2) run_case(off);
    summary();
    $finish;
  end
endmodule